// File: doc/BRIEF.md
# Next-PC Unit with Branch Delay Slot

This block sequences the program counter of a 32-bit processor whose control transfers have one architectural delay slot. Each time an instruction completes, the pipeline pulses a step input and presents that instruction's address, its decoded transfer kind, a signed word offset, a register operand, the compare flag, and the saved exception address and status. The block returns the address of the next instruction. It also returns the link-register write for calls and the status restore for exception return.

A taken branch or jump does not redirect the stream at once. Its target is parked in a pending register. The instruction that follows runs in the delay slot, and only when that instruction completes does the next address become the parked target. The link value written by calls therefore points past the delay slot. Exception return is the exception: it takes effect with no delay.

Transfer kind encoding on `kind_i` (3 bits): 0 none, 1 branch when flag set, 2 branch when flag clear, 3 relative jump, 4 relative call, 5 register jump, 6 register call, 7 exception return.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pending state clears: after that edge `pending_o` is 0 and `target_o` is 0. Pending state parked before the reset is lost.
- R2: Kind 1 is taken only when `flag_i` is 1, and kind 2 only when `flag_i` is 0. A taken branch sets `pending_o` after the step edge.
- R3: For kinds 1 to 4 the parked target is `pc_i` plus the sign-extended `off_i` times 4, taken modulo 2^32. This covers the most negative offset and wrap past the top of the address space.
- R4: On a step of kind 4 or 6, `link_we_o` is 1, `link_idx_o` is 9 and `link_val_o` is `pc_i`+8, in the same cycle. For every other kind `link_we_o` is 0.
- R5: For kinds 5 and 6 the parked target is `reg_tgt_i` exactly as given.
- R6: On the step after a taken transfer (the delay slot), `redirect_o` is 1 and `next_pc_o` equals the parked target, whatever the slot's own kind. After that step `pending_o` is 0, unless the slot itself is a taken transfer.
- R7: A step with no pending target, of kind 0 or a branch that is not taken, gives `next_pc_o` = `pc_i`+4 and `redirect_o` = 0, and leaves nothing pending.
- R8: A step of kind 7 with no pending target gives `next_pc_o` = `epc_i` in the same cycle, `sr_we_o` = 1 and `sr_val_o` = `esr_i`, and leaves nothing pending. `sr_we_o` is 0 for all other kinds.
- R9: A taken transfer inside a delay slot redirects to the earlier target and parks its own target, which is applied after the next step.
- R10: Cycles without `step_i` change nothing. The pending state holds, and `redirect_o`, `link_we_o` and `sr_we_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | An instruction completes this cycle |
| pc_i | input | 32 | Address of the completing instruction |
| kind_i | input | 3 | Transfer kind (encoding above) |
| off_i | input | 26 | Signed word offset for relative transfers |
| reg_tgt_i | input | 32 | Register operand used as the jump target |
| flag_i | input | 1 | Compare flag |
| epc_i | input | 32 | Saved exception address |
| esr_i | input | 32 | Saved status word |
| next_pc_o | output | 32 | Address of the next instruction |
| redirect_o | output | 1 | The next address is a parked target |
| pending_o | output | 1 | A target is parked |
| target_o | output | 32 | Parked target (0 when none) |
| link_we_o | output | 1 | Write the link register |
| link_idx_o | output | 5 | Link register index (9) |
| link_val_o | output | 32 | Link value |
| sr_we_o | output | 1 | Restore the status register |
| sr_val_o | output | 32 | Status value to restore |

## Verification
The bench builds the unit with its default widths: a 32-bit address and a 26-bit offset. With those widths both the largest negative offset (a 2^27-byte backward reach) and a forward jump that wraps past the top of the address space are reachable from chosen addresses. The default link index of 9 is checked at the port. Sequences place calls, register jumps and exception returns around delay slots, including a transfer inside a slot and idle gaps between a branch and its slot.

// File: rtl/npc_pkg.sv
// Package: shared types for the next-PC unit.
// Assumes the transfer kind arrives already decoded as a 3-bit code.
package npc_pkg;

    typedef enum logic [2:0] {
        XK_NONE     = 3'd0,
        XK_BR_SET   = 3'd1,
        XK_BR_CLR   = 3'd2,
        XK_JMP_REL  = 3'd3,
        XK_CALL_REL = 3'd4,
        XK_JMP_REG  = 3'd5,
        XK_CALL_REG = 3'd6,
        XK_EXC_RET  = 3'd7
    } xfer_kind_e;

    // Decoded control view of one completing instruction.
    typedef struct packed {
        logic taken;
        logic use_reg;
        logic is_call;
        logic is_ret;
    } xfer_ctl_t;

endpackage

// File: rtl/npc_decide.sv
// Module: npc_decide
// Turns the transfer kind and compare flag into control bits.
// Purely combinational. Assumes kind is valid whenever the caller
// qualifies the result with a step strobe.
module npc_decide
    import npc_pkg::*;
(
    input  logic [2:0]  kind_i,
    input  logic        flag_i,
    output xfer_ctl_t   ctl_o
);

    // Decode the kind into taken / operand source / call / return.
    always_comb begin
        ctl_o = '0;
        unique case (xfer_kind_e'(kind_i))
            XK_BR_SET:   ctl_o.taken = flag_i;
            XK_BR_CLR:   ctl_o.taken = ~flag_i;
            XK_JMP_REL:  ctl_o.taken = 1'b1;
            XK_CALL_REL: begin
                ctl_o.taken   = 1'b1;
                ctl_o.is_call = 1'b1;
            end
            XK_JMP_REG:  begin
                ctl_o.taken   = 1'b1;
                ctl_o.use_reg = 1'b1;
            end
            XK_CALL_REG: begin
                ctl_o.taken   = 1'b1;
                ctl_o.use_reg = 1'b1;
                ctl_o.is_call = 1'b1;
            end
            XK_EXC_RET:  ctl_o.is_ret = 1'b1;
            default:     ctl_o = '0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
// Module: npc_target
// Forms the transfer target: pc + sext(offset)*4, or the register operand.
// Assumes OFF_W+2 may be wider or narrower than XLEN. The sum wraps modulo 2^XLEN.
module npc_target #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 26
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [XLEN-1:0]  reg_i,
    input  logic             use_reg_i,
    output logic [XLEN-1:0]  tgt_o
);

    localparam int SH_W  = OFF_W + 2;
    localparam int EXT_W = XLEN - SH_W;

    logic [SH_W-1:0] off_sh;
    logic [XLEN-1:0] off_ext;

    assign off_sh = {off_i, 2'b00};

    // Widen or trim the byte offset to XLEN depending on the parameters.
    generate
        if (EXT_W > 0) begin : g_sext
            assign off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_sh};
        end else begin : g_trim
            assign off_ext = off_sh[XLEN-1:0];
        end
    endgenerate

    // Choose between the register operand and the relative sum.
    always_comb begin
        tgt_o = use_reg_i ? reg_i : (pc_i + off_ext);
    end

endmodule

// File: rtl/npc_pending.sv
// Module: npc_pending
// Holds the parked delay-slot target. It loads on a taken transfer and
// clears when the slot step consumes it or on reset.
// Assumes load_i is only meaningful together with step_i.
module npc_pending #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic            load_i,
    input  logic [XLEN-1:0] tgt_i,
    output logic            pend_o,
    output logic [XLEN-1:0] tgt_o
);

    // Park, replace or release the target on each completing step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            tgt_o  <= '0;
        end else if (step_i) begin
            if (load_i) begin
                pend_o <= 1'b1;
                tgt_o  <= tgt_i;
            end else begin
                pend_o <= 1'b0;
                tgt_o  <= '0;
            end
        end
    end

endmodule

// File: rtl/npc_unit.sv
// Module: npc_unit (top)
// Next-PC sequencer with one delay slot. A taken transfer parks its target,
// and the step after it (the slot) redirects there. Exception return
// redirects at once and restores status. Calls write pc+8 to the link register.
// Assumes one step per completing instruction, in program order.
module npc_unit #(
    parameter int XLEN     = 32,
    parameter int OFF_W    = 26,
    parameter int RIDX_W   = 5,
    parameter int LINK_IDX = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [2:0]        kind_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [XLEN-1:0]   reg_tgt_i,
    input  logic              flag_i,
    input  logic [XLEN-1:0]   epc_i,
    input  logic [XLEN-1:0]   esr_i,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              redirect_o,
    output logic              pending_o,
    output logic [XLEN-1:0]   target_o,
    output logic              link_we_o,
    output logic [RIDX_W-1:0] link_idx_o,
    output logic [XLEN-1:0]   link_val_o,
    output logic              sr_we_o,
    output logic [XLEN-1:0]   sr_val_o
);

    import npc_pkg::*;

    localparam logic [XLEN-1:0]   SEQ_STEP  = XLEN'(4);
    localparam logic [XLEN-1:0]   LINK_STEP = XLEN'(8);
    localparam logic [RIDX_W-1:0] LINK_SEL  = RIDX_W'(LINK_IDX);

    xfer_ctl_t       ctl;
    logic [XLEN-1:0] new_tgt;

    npc_decide u_decide (
        .kind_i (kind_i),
        .flag_i (flag_i),
        .ctl_o  (ctl)
    );

    npc_target #(.XLEN(XLEN), .OFF_W(OFF_W)) u_target (
        .pc_i      (pc_i),
        .off_i     (off_i),
        .reg_i     (reg_tgt_i),
        .use_reg_i (ctl.use_reg),
        .tgt_o     (new_tgt)
    );

    npc_pending #(.XLEN(XLEN)) u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_i),
        .load_i (ctl.taken),
        .tgt_i  (new_tgt),
        .pend_o (pending_o),
        .tgt_o  (target_o)
    );

    // Next address: parked target first, then exception return, then sequential.
    always_comb begin
        redirect_o = step_i & pending_o;
        if (pending_o)
            next_pc_o = target_o;
        else if (ctl.is_ret)
            next_pc_o = epc_i;
        else
            next_pc_o = pc_i + SEQ_STEP;
    end

    // Link-register write for calls; the value skips the delay slot.
    always_comb begin
        link_we_o  = step_i & ctl.is_call;
        link_idx_o = LINK_SEL;
        link_val_o = pc_i + LINK_STEP;
    end

    // Status restore on exception return.
    always_comb begin
        sr_we_o  = step_i & ctl.is_ret;
        sr_val_o = esr_i;
    end

endmodule

// File: rtl/npc_unit_chk.sv
// Module: npc_unit_chk
// Property checker for npc_unit. It observes ports only and is bound below.
module npc_unit_chk #(
    parameter int XLEN     = 32,
    parameter int OFF_W    = 26,
    parameter int RIDX_W   = 5,
    parameter int LINK_IDX = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_i,
    input logic [XLEN-1:0]   pc_i,
    input logic [2:0]        kind_i,
    input logic [OFF_W-1:0]  off_i,
    input logic [XLEN-1:0]   reg_tgt_i,
    input logic              flag_i,
    input logic [XLEN-1:0]   epc_i,
    input logic [XLEN-1:0]   esr_i,
    input logic [XLEN-1:0]   next_pc_o,
    input logic              redirect_o,
    input logic              pending_o,
    input logic [XLEN-1:0]   target_o,
    input logic              link_we_o,
    input logic [RIDX_W-1:0] link_idx_o,
    input logic [XLEN-1:0]   link_val_o,
    input logic              sr_we_o,
    input logic [XLEN-1:0]   sr_val_o
);

    // A reset edge empties the pending state.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!pending_o && target_o == '0));

    // A branch on a set flag with the flag set parks a target.
    p_branch_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && kind_i == 3'd1 && flag_i) |=> pending_o);

    // A branch on a clear flag with the flag set is not taken.
    p_branch_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && kind_i == 3'd2 && flag_i) |=> !pending_o);

    // Calls write pc+8 to link register 9.
    p_link_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && (kind_i == 3'd4 || kind_i == 3'd6)) |->
        (link_we_o && link_val_o == pc_i + XLEN'(8) && link_idx_o == RIDX_W'(LINK_IDX)));

    // A register jump parks the register operand.
    p_reg_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && kind_i == 3'd5) |=> (pending_o && target_o == $past(reg_tgt_i)));

    // The slot step redirects to the parked target.
    p_slot_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && pending_o) |-> (redirect_o && next_pc_o == target_o));

    // A plain slot step releases the parked target.
    p_slot_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && pending_o && kind_i == 3'd0) |=> !pending_o);

    // Exception return with nothing parked jumps at once and restores status.
    p_exc_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && kind_i == 3'd7 && !pending_o) |->
        (sr_we_o && sr_val_o == esr_i && next_pc_o == epc_i));

    // Idle cycles leave the state alone and raise no strobe.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(pending_o) && $stable(target_o)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |-> (!redirect_o && !link_we_o && !sr_we_o));

endmodule

bind npc_unit npc_unit_chk #(
    .XLEN(XLEN), .OFF_W(OFF_W), .RIDX_W(RIDX_W), .LINK_IDX(LINK_IDX)
) u_npc_chk (.*);

// File: tb/tb_npc_unit.sv
// Scoreboard bench for npc_unit. The driver computes expectations from the
// requirements and queues them. The monitor compares them mid-cycle.
module tb_npc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic [2:0]  kind_i = '0;
    logic [25:0] off_i = '0;
    logic [31:0] reg_tgt_i = '0;
    logic        flag_i = 1'b0;
    logic [31:0] epc_i = '0;
    logic [31:0] esr_i = '0;
    logic [31:0] next_pc_o;
    logic        redirect_o;
    logic        pending_o;
    logic [31:0] target_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;
    logic [31:0] link_val_o;
    logic        sr_we_o;
    logic [31:0] sr_val_o;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        string       tag;
        logic [31:0] next_pc;
        logic        redirect;
        logic        pending;
        logic [31:0] target;
        logic        link_we;
        logic [31:0] link_val;
        logic        sr_we;
        logic [31:0] sr_val;
    } exp_t;

    exp_t q[$];

    // Bench model of the parked target.
    logic        m_pend = 1'b0;
    logic [31:0] m_tgt  = '0;

    always #4 clk = ~clk;

    npc_unit dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one completing instruction and queue what must be seen.
    task automatic issue(input string tag, input logic [2:0] k, input logic [31:0] pc,
                         input logic [25:0] off, input logic [31:0] rg,
                         input logic fl, input logic [31:0] epc, input logic [31:0] esr);
        exp_t e;
        bit taken;
        logic [31:0] tgt;
        @(negedge clk);
        step_i = 1'b1; kind_i = k; pc_i = pc; off_i = off;
        reg_tgt_i = rg; flag_i = fl; epc_i = epc; esr_i = esr;
        taken = (k == 3'd1 && fl) || (k == 3'd2 && !fl) || (k >= 3'd3 && k <= 3'd6);
        tgt = (k == 3'd5 || k == 3'd6) ? rg : pc + {{4{off[25]}}, off, 2'b00};
        e.tag      = tag;
        e.pending  = m_pend;
        e.target   = m_tgt;
        e.redirect = m_pend;
        e.next_pc  = m_pend ? m_tgt : (k == 3'd7 ? epc : pc + 32'd4);
        e.link_we  = (k == 3'd4 || k == 3'd6);
        e.link_val = pc + 32'd8;
        e.sr_we    = (k == 3'd7);
        e.sr_val   = esr;
        q.push_back(e);
        m_pend = taken;
        m_tgt  = taken ? tgt : 32'd0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_i = 1'b0;
        end
    endtask

    // Monitor: compare queued expectations midway through each step cycle.
    always @(negedge clk) begin
        #2;
        if (rst_n && step_i) begin
            if (q.size() == 0) begin
                chk(0, "scoreboard underflow", 0, 1);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(next_pc_o == e.next_pc, {e.tag, " next_pc"}, next_pc_o, e.next_pc);
                chk(redirect_o == e.redirect, {e.tag, " redirect"}, 32'(redirect_o), 32'(e.redirect));
                chk(pending_o == e.pending, {e.tag, " pending"}, 32'(pending_o), 32'(e.pending));
                chk(target_o == e.target, {e.tag, " target"}, target_o, e.target);
                chk(link_we_o == e.link_we, {e.tag, " link_we (R4)"}, 32'(link_we_o), 32'(e.link_we));
                if (e.link_we) begin
                    chk(link_val_o == e.link_val, {e.tag, " link_val (R4)"}, link_val_o, e.link_val);
                    chk(link_idx_o == 5'd9, {e.tag, " link_idx (R4)"}, 32'(link_idx_o), 32'd9);
                end
                chk(sr_we_o == e.sr_we, {e.tag, " sr_we (R8)"}, 32'(sr_we_o), 32'(e.sr_we));
                if (e.sr_we)
                    chk(sr_val_o == e.sr_val, {e.tag, " sr_val (R8)"}, sr_val_o, e.sr_val);
            end
        end else if (rst_n) begin
            chk(!redirect_o && !link_we_o && !sr_we_o, "R10 idle strobes",
                {29'd0, redirect_o, link_we_o, sr_we_o}, 32'd0);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk(!pending_o && target_o == 0 && !redirect_o, "R1 reset state",
            {31'd0, pending_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        issue("R7 plain step", 3'd0, 32'h100, 26'd0, 0, 1'b0, 0, 0);
        issue("R2 R7 set-branch flag clear", 3'd1, 32'h104, 26'h10, 0, 1'b0, 0, 0);
        issue("R2 set-branch flag set", 3'd1, 32'h108, 26'h10, 0, 1'b1, 0, 0);
        issue("R6 slot after branch", 3'd0, 32'h10C, 26'd0, 0, 1'b0, 0, 0);
        issue("R2 R3 clear-branch back", 3'd2, 32'h148, 26'h3FFFFFC, 0, 1'b0, 0, 0);
        issue("R6 slot after back branch", 3'd0, 32'h14C, 26'd0, 0, 1'b0, 0, 0);
        issue("R2 clear-branch flag set", 3'd2, 32'h138, 26'h20, 0, 1'b1, 0, 0);
        issue("R4 relative call", 3'd4, 32'h200, 26'h100, 0, 1'b0, 0, 0);
        idle(3);
        issue("R10 R6 slot after idle gap", 3'd0, 32'h204, 26'd0, 0, 1'b0, 0, 0);
        issue("R5 register jump", 3'd5, 32'h600, 26'h55, 32'hDEAD_BEE0, 1'b0, 0, 0);
        issue("R6 slot after register jump", 3'd0, 32'h604, 26'd0, 0, 1'b0, 0, 0);
        issue("R4 R5 register call", 3'd6, 32'hDEAD_BEE0, 26'd0, 32'h40, 1'b1, 0, 0);
        issue("R6 slot after register call", 3'd0, 32'hDEAD_BEE4, 26'd0, 0, 1'b0, 0, 0);
        issue("R3 jump wrapping top", 3'd3, 32'hFFFF_FFF0, 26'd8, 0, 1'b0, 0, 0);
        issue("R3 slot after wrap", 3'd0, 32'hFFFF_FFF4, 26'd0, 0, 1'b0, 0, 0);
        issue("R3 most negative offset", 3'd3, 32'h1000, 26'h2000000, 0, 1'b0, 0, 0);
        issue("R3 slot after far jump", 3'd0, 32'h1004, 26'd0, 0, 1'b0, 0, 0);
        issue("R8 exception return", 3'd7, 32'h0800, 26'd0, 0, 1'b0, 32'h2000, 32'h8001);
        issue("R7 after return", 3'd0, 32'h2000, 26'd0, 0, 1'b0, 0, 0);
        issue("R9 jump before nested", 3'd3, 32'h300, 26'd4, 0, 1'b0, 0, 0);
        issue("R9 register jump in slot", 3'd5, 32'h304, 26'd0, 32'h500, 1'b0, 0, 0);
        issue("R9 slot of nested jump", 3'd0, 32'h310, 26'd0, 0, 1'b0, 0, 0);
        issue("R7 sequential resumes", 3'd0, 32'h500, 26'd0, 0, 1'b0, 0, 0);
        issue("R1 branch before reset", 3'd1, 32'h700, 26'h8, 0, 1'b1, 0, 0);

        // Mid-run reset drops the parked target.
        @(negedge clk);
        step_i = 1'b0;
        rst_n  = 1'b0;
        @(negedge clk);
        #2;
        chk(!pending_o && target_o == 0, "R1 reset clears pending", target_o, 32'd0);
        m_pend = 1'b0;
        m_tgt  = '0;
        rst_n  = 1'b1;
        issue("R1 R7 first step after reset", 3'd0, 32'h704, 26'd0, 0, 1'b0, 0, 0);

        idle(2);
        wait (q.size() == 0);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule